// File: doc/BRIEF.md
# Slew-Limited CPU Frequency Selector

This block turns a three-bit frequency select into a CPU clock frequency command. The command never jumps. It walks toward each new target at a bounded rate, so that loops further down the clock tree keep their lock. Each of the eight select codes has its own programmable table entry. The table arrives as one packed input vector. Code `i` occupies bits `[i*WORD_W +: WORD_W]`. An entry of zero means "off". Any nonzero entry is a frequency word. A select code takes effect only after the select lines have stayed unchanged for a set number of cycles.

A millisecond-rate strobe paces a ramp engine. On each strobe the engine moves the current frequency word at most one fixed step toward the adopted target, and it never passes that target. The word stays inside a legal band `[MIN_WORD, MAX_WORD]`, or it is zero when the clock is stopped. Leaving "off" begins at the floor of the band. Entering "off" ramps down to the floor and then stops the clock. The current word drives a phase accumulator. The most significant bit of the accumulator is the generated CPU clock.

Top module: `cpu_freq_slewer`

## Requirements
- R1: A select code is adopted only after the select lines have held one value for SETTLE_CYCLES consecutive clock edges. A select that changes more often than that leaves the target unchanged.
- R2: `curWord` changes only on the clock edge that samples `rateTick` high.
- R3: On a strobe, a nonzero `curWord` moves toward its aim by at most STEP_WORD. It lands exactly on the aim when the aim is closer than one step, and it never overshoots.
- R4: A table entry of zero means off. When `curWord` is zero and the target is nonzero, the next strobe loads MIN_WORD.
- R5: When the target is off, strobes ramp `curWord` down to MIN_WORD. The strobe that finds `curWord` at MIN_WORD sets it to zero.
- R6: A nonzero entry below MIN_WORD is treated as MIN_WORD. An entry above MAX_WORD is treated as MAX_WORD. `curWord` is always zero or inside the band.
- R7: `settled` is high exactly when `curWord` equals the target, with the target taken as zero when it is off.
- R8: `cpuClk` is the MSB of an ACC_W-bit accumulator that adds `curWord` on every clock. With a constant word F, `cpuClk` shows exactly F rising edges in every 2^ACC_W cycles. While the word is zero, the clock stays low.
- R9: After reset, `curWord` is zero, `cpuClk` is low and select code 0 is the adopted code.
- R10: A strobe on the same edge that adopts a new code still steps toward the previously adopted target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| sel | input | SEL_W | Frequency select code |
| cfgTable | input | (2^SEL_W)*WORD_W | Packed table; entry i at [i*WORD_W +: WORD_W]; zero is off |
| rateTick | input | 1 | One-cycle strobe that paces the ramp |
| curWord | output | WORD_W | Current frequency word |
| settled | output | 1 | High when curWord equals the target |
| cpuClk | output | 1 | Generated CPU clock |

## Verification
Two functions can fall on the same edge: the adoption of a newly stable select code and a ramp strobe. The bench raises the select against a settled word and places the strobe exactly on the edge that completes the stability window. It then expects the word to stay where the old target holds it and `settled` to drop, and the following strobe to begin the move toward the new target. The other sweeps cover every table code, glitching selects, the transitions into and out of off, and edge counts of the generated clock. All of these are judged against a step model that the bench computes in plain arithmetic.

// File: rtl/freq_slew_pkg.sv
package freq_slew_pkg;
  // Strobes from the control unit to the datapath; at most one is high.
  typedef struct packed {
    logic loadFloor;
    logic rampUp;
    logic rampDown;
    logic halt;
  } slewCmd_t;
endpackage

// File: rtl/freq_slew_ctrl.sv
module freq_slew_ctrl
  import freq_slew_pkg::*;
#(
  parameter int SEL_W         = 3,
  parameter int WORD_W        = 12,
  parameter int MIN_WORD      = 64,
  parameter int MAX_WORD      = 1600,
  parameter int SETTLE_CYCLES = 4
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [SEL_W-1:0]                  sel,
  input  logic [(2**SEL_W)*WORD_W-1:0]      cfgTable,
  input  logic                              rateTick,
  input  logic [WORD_W-1:0]                 curWord,
  output logic [WORD_W-1:0]                 aimWord,
  output logic [WORD_W-1:0]                 targetWord,
  output slewCmd_t                          cmd
);
  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CNT_W-1:0]  SETTLE_C = CNT_W'(SETTLE_CYCLES);
  localparam logic [WORD_W-1:0] MIN_W    = WORD_W'(MIN_WORD);
  localparam logic [WORD_W-1:0] MAX_W    = WORD_W'(MAX_WORD);

  logic [SEL_W-1:0]  selSeen;
  logic [SEL_W-1:0]  selTaken;
  logic [CNT_W-1:0]  holdCnt;
  logic [WORD_W-1:0] rawEntry;
  logic              isOff;

  // Select stability filter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      selSeen  <= '0;
      selTaken <= '0;
      holdCnt  <= SETTLE_C;
    end else begin
      selSeen <= sel;
      if (sel != selSeen)
        holdCnt <= '0;
      else if (holdCnt != SETTLE_C)
        holdCnt <= holdCnt + 1'b1;
      if (holdCnt == SETTLE_C)
        selTaken <= selSeen;
    end
  end

  // Table lookup and band clamp
  always_comb begin
    rawEntry = cfgTable[selTaken*WORD_W +: WORD_W];
    isOff    = (rawEntry == '0);
    if (isOff)
      targetWord = '0;
    else if (rawEntry < MIN_W)
      targetWord = MIN_W;
    else if (rawEntry > MAX_W)
      targetWord = MAX_W;
    else
      targetWord = rawEntry;
    aimWord = isOff ? MIN_W : targetWord;
  end

  // Strobe decode
  always_comb begin
    cmd = '0;
    if (rateTick) begin
      if (curWord == '0)
        cmd.loadFloor = !isOff;
      else if (isOff && curWord == MIN_W)
        cmd.halt = 1'b1;
      else if (curWord < aimWord)
        cmd.rampUp = 1'b1;
      else if (curWord > aimWord)
        cmd.rampDown = 1'b1;
    end
  end

  p_move_only_on_tick_r2: assert property (@(posedge clk) disable iff (!rstN)
    !rateTick |=> $stable(curWord));
  p_off_start_floor_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rateTick && curWord == '0 && targetWord != '0) |=> (curWord == MIN_W));
  p_halt_from_floor_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rateTick && curWord == MIN_W && targetWord == '0) |=> (curWord == '0));
  p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(cmd));
endmodule

// File: rtl/freq_slew_dp.sv
module freq_slew_dp
  import freq_slew_pkg::*;
#(
  parameter int WORD_W    = 12,
  parameter int ACC_W     = 12,
  parameter int MIN_WORD  = 64,
  parameter int MAX_WORD  = 1600,
  parameter int STEP_WORD = 100
) (
  input  logic              clk,
  input  logic              rstN,
  input  slewCmd_t          cmd,
  input  logic [WORD_W-1:0] aimWord,
  output logic [WORD_W-1:0] curWord,
  output logic              cpuClk
);
  localparam logic [WORD_W-1:0] MIN_W  = WORD_W'(MIN_WORD);
  localparam logic [WORD_W-1:0] MAX_W  = WORD_W'(MAX_WORD);
  localparam logic [WORD_W-1:0] STEP_W = WORD_W'(STEP_WORD);

  logic [WORD_W-1:0] nextWord;
  logic [ACC_W-1:0]  phaseAcc;

  always_comb begin
    nextWord = curWord;
    if (cmd.loadFloor)
      nextWord = MIN_W;
    else if (cmd.halt)
      nextWord = '0;
    else if (cmd.rampUp)
      nextWord = ((aimWord - curWord) > STEP_W) ? curWord + STEP_W : aimWord;
    else if (cmd.rampDown)
      nextWord = ((curWord - aimWord) > STEP_W) ? curWord - STEP_W : aimWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curWord  <= '0;
      phaseAcc <= '0;
    end else begin
      curWord <= nextWord;
      if (curWord == '0)
        phaseAcc <= '0;
      else
        phaseAcc <= phaseAcc + ACC_W'(curWord);
    end
  end

  assign cpuClk = phaseAcc[ACC_W-1];

  p_step_up_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(curWord) != '0 && curWord > $past(curWord)) |-> ((curWord - $past(curWord)) <= STEP_W));
  p_step_down_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    (curWord != '0 && curWord < $past(curWord)) |-> (($past(curWord) - curWord) <= STEP_W));
  p_band_r6: assert property (@(posedge clk) disable iff (!rstN)
    (curWord == '0) || (curWord >= MIN_W && curWord <= MAX_W));
  p_clock_low_when_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    (curWord == '0) |=> !cpuClk);
endmodule

// File: rtl/cpu_freq_slewer.sv
module cpu_freq_slewer
  import freq_slew_pkg::*;
#(
  parameter int SEL_W         = 3,
  parameter int WORD_W        = 12,
  parameter int ACC_W         = 12,
  parameter int MIN_WORD      = 64,
  parameter int MAX_WORD      = 1600,
  parameter int STEP_WORD     = 100,
  parameter int SETTLE_CYCLES = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [SEL_W-1:0]             sel,
  input  logic [(2**SEL_W)*WORD_W-1:0] cfgTable,
  input  logic                         rateTick,
  output logic [WORD_W-1:0]            curWord,
  output logic                         settled,
  output logic                         cpuClk
);
  slewCmd_t          cmd;
  logic [WORD_W-1:0] aimWord;
  logic [WORD_W-1:0] targetWord;

  freq_slew_ctrl #(
    .SEL_W(SEL_W), .WORD_W(WORD_W), .MIN_WORD(MIN_WORD),
    .MAX_WORD(MAX_WORD), .SETTLE_CYCLES(SETTLE_CYCLES)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .sel(sel), .cfgTable(cfgTable),
    .rateTick(rateTick), .curWord(curWord), .aimWord(aimWord),
    .targetWord(targetWord), .cmd(cmd)
  );

  freq_slew_dp #(
    .WORD_W(WORD_W), .ACC_W(ACC_W), .MIN_WORD(MIN_WORD),
    .MAX_WORD(MAX_WORD), .STEP_WORD(STEP_WORD)
  ) i_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .aimWord(aimWord),
    .curWord(curWord), .cpuClk(cpuClk)
  );

  assign settled = (curWord == targetWord);
endmodule

// File: tb/test_cpu_freq_slewer.sv
`timescale 1ns/1ps
module test_cpu_freq_slewer;
  localparam int SEL_W = 3, WORD_W = 12, ACC_W = 12;
  localparam int MINW = 64, MAXW = 1600, STEP = 100, SETTLE = 4;
  localparam int NCODE = 1 << SEL_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [SEL_W-1:0] sel = '0;
  logic [NCODE*WORD_W-1:0] cfgTable = '0;
  logic rateTick = 1'b0;
  logic [WORD_W-1:0] curWord;
  logic settled, cpuClk;

  int nChecks = 0, nFails = 0;
  int entry[NCODE];
  int expCur = 0, expTgt = 0;

  always #4 clk = ~clk;

  cpu_freq_slewer #(
    .SEL_W(SEL_W), .WORD_W(WORD_W), .ACC_W(ACC_W), .MIN_WORD(MINW),
    .MAX_WORD(MAXW), .STEP_WORD(STEP), .SETTLE_CYCLES(SETTLE)
  ) i_cpu_freq_slewer (
    .clk(clk), .rstN(rstN), .sel(sel), .cfgTable(cfgTable),
    .rateTick(rateTick), .curWord(curWord), .settled(settled), .cpuClk(cpuClk)
  );

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int tgtOf(int e);
    if (e == 0) return 0;
    if (e < MINW) return MINW;
    if (e > MAXW) return MAXW;
    return e;
  endfunction

  function automatic int nextOf(int c, int t);
    if (t == 0) begin
      if (c == 0 || c == MINW) return 0;
      return (c - MINW > STEP) ? c - STEP : MINW;
    end
    if (c == 0) return MINW;
    if (c < t) return (t - c > STEP) ? c + STEP : t;
    if (c > t) return (c - t > STEP) ? c - STEP : t;
    return c;
  endfunction

  task automatic tick();
    @(negedge clk); rateTick = 1'b1;
    @(negedge clk); rateTick = 1'b0;
    expCur = nextOf(expCur, expTgt);
    check("R3 step", int'(curWord), expCur);
    check("R7 settled", int'(settled), int'(expCur == expTgt));
  endtask

  task automatic pick(int code);
    @(negedge clk); sel = SEL_W'(code);
    repeat (SETTLE + 3) @(negedge clk);
    expTgt = tgtOf(entry[code]);
    check("R2 no move without tick", int'(curWord), expCur);
    check("R6 target/settled", int'(settled), int'(expCur == expTgt));
  endtask

  task automatic rampOut();
    for (int k = 0; k < 40 && expCur != nextOf(expCur, expTgt); k++) tick();
    tick();
  endtask

  task automatic countEdges(int cycles, int exp, string req);
    int rises = 0;
    logic prev;
    @(negedge clk); prev = cpuClk;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      if (cpuClk && !prev) rises++;
      prev = cpuClk;
    end
    check(req, rises, exp);
  endtask

  initial begin
    #(200000 * 8);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    entry = '{0, 300, 1600, 20, 3000, 64, 777, 0};
    for (int i = 0; i < NCODE; i++) cfgTable[i*WORD_W +: WORD_W] = WORD_W'(entry[i]);
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 reset word", int'(curWord), 0);
    check("R9 reset clock", int'(cpuClk), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R9 code0 adopted, settled", int'(settled), 1);
    tick();  // off stays off
    // R4: off -> nonzero starts at floor, then ramps
    pick(1);
    tick();
    check("R4 floor start", int'(curWord), MINW);
    rampOut();
    // sweep codes, including clamps (R6) and off (R5)
    foreach (entry[i]) begin
      pick((i * 3 + 2) % NCODE);
      rampOut();
    end
    // R6 clamp high and generated clock at a known word (R8)
    pick(4); rampOut();
    check("R6 clamp high", int'(curWord), MAXW);
    pick(6); rampOut();
    countEdges(1 << ACC_W, 777, "R8 edges at 777");
    pick(3); rampOut();
    check("R6 clamp low", int'(curWord), MINW);
    countEdges(1 << ACC_W, MINW, "R8 edges at floor");
    // R5: to off, ramps to floor then halts
    pick(6); rampOut();
    pick(7); rampOut();
    check("R5 stopped", int'(curWord), 0);
    countEdges(300, 0, "R8 clock low when off");
    // R1: glitching select ignored
    pick(1); rampOut();
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); sel = 3'd2;
      @(negedge clk); rateTick = 1'b1;
      @(negedge clk); rateTick = 1'b0; sel = 3'd6;
      @(negedge clk);
      check("R1 glitch ignored", int'(curWord), 300);
    end
    @(negedge clk); sel = 3'd1;
    repeat (SETTLE + 3) @(negedge clk);
    tick();
    check("R1 still at 300", int'(curWord), 300);
    // R10: strobe on the adoption edge uses the old target
    @(negedge clk); sel = 3'd2;
    repeat (SETTLE + 1) @(negedge clk);
    rateTick = 1'b1;
    @(negedge clk); rateTick = 1'b0;
    check("R10 old target kept", int'(curWord), 300);
    check("R10 settled drops", int'(settled), 0);
    expTgt = tgtOf(entry[2]);
    tick();
    check("R10 next step new target", int'(curWord), 400);
    rampOut();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule